// File: doc/BRIEF.md
# Seconds Real-Time Clock with Guarded Register Writes

This block is a real-time clock peripheral on a plain 32-bit register bus. A 32-bit seconds count advances on each pulse of a one-cycle 1 Hz strobe while counting is enabled. The count is compared against an alarm word. A combined control and status word holds sticky event flags for "a second elapsed" and "alarm matched", and an interrupt enable for each. A level interrupt output combines the flags with their enables. A hibernate word raises a power-off request. A scratchpad word survives reset, so software can place a signature in it and later check whether the clock's state was lost. A regulator word is plain storage.

Every register write goes through a slow commit path. A write is taken only while the write-ready status bit reads 1. The bit then falls for a fixed number of clock cycles, and the new value lands in the same cycle in which ready rises again. Software polls ready before each write. Because the event flags clear when a 0 is written to them, any write to the control word must carry 1s in the flag positions it wants to keep.

Top module: `secs_rtc`

## Requirements
- R1: After reset, the control word at offset 0x00 reads 0x80 (only ready set), the seconds count at 0x04 and the alarm word at 0x08 read 0, poweroff_req is 0 and irq is 0.
- R2: A write (wr_en high at a clock edge) is taken only when ready (control bit 7) is 1. After a taken write, ready reads 0 for exactly WR_LAT cycles (default 4) and then returns to 1. A write presented while ready is 0 has no effect.
- R3: A taken write changes the addressed register only in the cycle in which ready rises again. While ready is 0, the register still reads its old value.
- R4: The seconds count at 0x04 adds one on each tick_1hz pulse only while the count enable (control bit 0) is 1. It wraps from 0xFFFFFFFF to 0, and it can be loaded by a write.
- R5: The one-second flag (control bit 6) becomes 1 on every increment of the seconds count.
- R6: The alarm flag (control bit 4) becomes 1 when the alarm enable (control bit 2) is 1 and the seconds count equals the alarm word at 0x08.
- R7: Writing 0 to control bit 6 or bit 4 clears that flag. Writing 1 leaves it unchanged. Bits 5, 3, 2 and 0 take the written value.
- R8: irq is 1 exactly while (bit 6 AND the one-second interrupt enable, bit 5) OR (bit 4 AND the alarm interrupt enable, bit 3) holds.
- R9: Writing a value with bit 0 set to the hibernate word at 0x20 raises poweroff_req, which stays high until reset. Writing a value with bit 0 clear does not raise it.
- R10: The scratchpad at 0x34 and the regulator word at 0x0C are 32-bit words that read back what was last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle strobe, once per second |
| wr_en | input | 1 | Write request |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| irq | output | 1 | Level interrupt |
| poweroff_req | output | 1 | Power-off request |

## Verification
The commit path is tested in three ways: a write to the seconds count that is read back while ready is low, a second write presented in the middle of that busy window, and single writes to each storage word. Together these separate "ignored", "late commit" and "early commit" behaviour. The counter is driven with ticks while it is disabled, while it is enabled, and across the 0xFFFFFFFF boundary, which distinguishes gating errors from wrap errors. Control writes with the flag bits set to 1 and then to 0 show whether the write-zero-to-clear rule holds and whether irq follows each flag-enable pair. An alarm set two seconds ahead checks the match against the count.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 8;

  localparam logic [AW-1:0] OFS_CTRL  = 8'h00;
  localparam logic [AW-1:0] OFS_SECS  = 8'h04;
  localparam logic [AW-1:0] OFS_ALARM = 8'h08;
  localparam logic [AW-1:0] OFS_REGL  = 8'h0C;
  localparam logic [AW-1:0] OFS_HIBR  = 8'h20;
  localparam logic [AW-1:0] OFS_SCRT  = 8'h34;

  localparam int unsigned B_RDY  = 7;
  localparam int unsigned B_SFLG = 6;
  localparam int unsigned B_SIE  = 5;
  localparam int unsigned B_AFLG = 4;
  localparam int unsigned B_AIE  = 3;
  localparam int unsigned B_AEN  = 2;
  localparam int unsigned B_CEN  = 0;
endpackage

// File: rtl/rtc_wpath.sv
module rtc_wpath #(
  parameter int unsigned AW     = 8,
  parameter int unsigned DW     = 32,
  parameter int unsigned WR_LAT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          ready,
  output logic          commit,
  output logic [AW-1:0] c_addr,
  output logic [DW-1:0] c_data
);
  localparam int unsigned CW = $clog2(WR_LAT + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          take;

  assign ready  = (cnt_q == '0);
  assign take   = wr_en && ready;
  assign commit = (cnt_q == CW'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (take)       cnt_d = CW'(WR_LAT);
    else if (!ready) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Captured write, loaded only when accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_addr <= '0;
      c_data <= '0;
    end else if (take) begin
      c_addr <= addr;
      c_data <= wdata;
    end
  end

  a_r2_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ready) |=> !ready);
  a_r2_capture_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !commit) |=> $stable(c_data) && $stable(c_addr));
  a_r3_ready_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> ready);
endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cnt_en,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          alarm_en,
  input  logic [DW-1:0] alarm_val,
  input  logic          flag_wr,
  input  logic          keep_sflag,
  input  logic          keep_aflag,
  output logic [DW-1:0] secs,
  output logic          sflag,
  output logic          aflag
);
  logic [DW-1:0] secs_d;
  logic          sflag_d, aflag_d;
  logic          inc, match;

  assign inc   = tick && cnt_en && !load;
  assign match = alarm_en && (secs == alarm_val);

  always_comb begin
    secs_d = secs;
    if (load)     secs_d = load_val;
    else if (inc) secs_d = secs + DW'(1);
  end

  always_comb begin
    sflag_d = sflag;
    aflag_d = aflag;
    if (flag_wr) begin
      sflag_d = sflag & keep_sflag;
      aflag_d = aflag & keep_aflag;
    end
    if (inc)   sflag_d = 1'b1;
    if (match) aflag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      secs  <= '0;
      sflag <= 1'b0;
      aflag <= 1'b0;
    end else begin
      secs  <= secs_d;
      sflag <= sflag_d;
      aflag <= aflag_d;
    end
  end

  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_en && !load) |=> secs == $past(secs) + DW'(1));
  a_r4_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(tick && cnt_en) && !load) |=> $stable(secs));
  a_r5_flag_on_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_en && !load) |=> sflag);
  a_r6_alarm_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_en && secs == alarm_val) |=> aflag);
endmodule

// File: rtl/secs_rtc.sv
module secs_rtc #(
  parameter int unsigned WR_LAT = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_1hz,
  input  logic        wr_en,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq,
  output logic        poweroff_req
);
  import rtc_pkg::*;

  logic          ready, commit;
  logic [AW-1:0] c_addr;
  logic [DW-1:0] c_data;
  logic [DW-1:0] secs, alarm_q, regl_q, scrt_q;
  logic          sflag, aflag;
  logic          cen_q, aen_q, aie_q, sie_q;
  logic          wr_ctrl, wr_secs, wr_alarm, wr_regl, wr_hibr, wr_scrt;

  rtc_wpath #(.AW(AW), .DW(DW), .WR_LAT(WR_LAT)) u_wpath (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .ready(ready), .commit(commit), .c_addr(c_addr), .c_data(c_data)
  );

  assign wr_ctrl  = commit && (c_addr == OFS_CTRL);
  assign wr_secs  = commit && (c_addr == OFS_SECS);
  assign wr_alarm = commit && (c_addr == OFS_ALARM);
  assign wr_regl  = commit && (c_addr == OFS_REGL);
  assign wr_hibr  = commit && (c_addr == OFS_HIBR);
  assign wr_scrt  = commit && (c_addr == OFS_SCRT);

  rtc_timebase #(.DW(DW)) u_tb (
    .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .cnt_en(cen_q),
    .load(wr_secs), .load_val(c_data),
    .alarm_en(aen_q), .alarm_val(alarm_q),
    .flag_wr(wr_ctrl), .keep_sflag(c_data[B_SFLG]), .keep_aflag(c_data[B_AFLG]),
    .secs(secs), .sflag(sflag), .aflag(aflag)
  );

  // Control enables, alarm word, hibernate request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cen_q <= 1'b0;
      aen_q <= 1'b0;
      aie_q <= 1'b0;
      sie_q <= 1'b0;
    end else if (wr_ctrl) begin
      cen_q <= c_data[B_CEN];
      aen_q <= c_data[B_AEN];
      aie_q <= c_data[B_AIE];
      sie_q <= c_data[B_SIE];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        alarm_q <= '0;
    else if (wr_alarm) alarm_q <= c_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        regl_q <= '0;
    else if (wr_regl)  regl_q <= c_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      poweroff_req <= 1'b0;
    else if (wr_hibr && c_data[0])   poweroff_req <= 1'b1;
  end

  // Scratchpad deliberately outside reset: it must outlive it
  always_ff @(posedge clk) begin
    if (wr_scrt) scrt_q <= c_data;
  end

  assign irq = (sflag && sie_q) || (aflag && aie_q);

  always_comb begin
    rdata = '0;
    unique case (addr)
      OFS_CTRL: begin
        rdata[B_RDY]  = ready;
        rdata[B_SFLG] = sflag;
        rdata[B_SIE]  = sie_q;
        rdata[B_AFLG] = aflag;
        rdata[B_AIE]  = aie_q;
        rdata[B_AEN]  = aen_q;
        rdata[B_CEN]  = cen_q;
      end
      OFS_SECS:  rdata = secs;
      OFS_ALARM: rdata = alarm_q;
      OFS_REGL:  rdata = regl_q;
      OFS_HIBR:  rdata = {{(DW-1){1'b0}}, poweroff_req};
      OFS_SCRT:  rdata = scrt_q;
      default:   rdata = '0;
    endcase
  end

  a_r9_poweroff_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    poweroff_req |=> poweroff_req);
  a_r7_flag_kept_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && c_data[B_SFLG] && sflag) |=> sflag);
  a_r3_alarm_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_alarm |=> $stable(alarm_q));
endmodule

// File: tb/sim_secs_rtc.sv
module sim_secs_rtc;
  logic        clk, rst_n, tick_1hz, wr_en;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  logic        irq, poweroff_req;
  int checks = 0;
  int errors = 0;
  bit done = 0;
  int cyc = 0;

  secs_rtc u0 (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq),
    .poweroff_req(poweroff_req)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic wait_rdy();
    logic [31:0] c;
    rd(8'h00, c);
    while (!c[7]) rd(8'h00, c);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    wait_rdy();
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    wait_rdy();
  endtask

  task automatic tick();
    @(negedge clk);
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h00, v); chk("R1 ctrl", v, 32'h80);
    rd(8'h04, v); chk("R1 secs", v, 0);
    rd(8'h08, v); chk("R1 alarm", v, 0);
    chk("R1 poweroff", poweroff_req, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_commit();
    logic [31:0] v;
    int lows;
    wait_rdy();
    addr = 8'h04; wdata = 32'h100; wr_en = 1'b1;
    @(negedge clk);
    // R2: a second write while busy must be dropped
    addr = 8'h08; wdata = 32'h55;
    @(negedge clk);
    wr_en = 1'b0;
    addr = 8'h04; #1;
    chk("R3 old value while busy", rdata, 0);
    lows = 0;
    for (int i = 0; i < 10; i++) begin
      addr = 8'h00; #1;
      if (!rdata[7]) lows++;
      @(negedge clk);
    end
    // lows counted from first busy sample (one sample before loop already busy)
    chk("R2 busy cycles", lows + 1, 4);
    rd(8'h04, v); chk("R3 committed secs", v, 32'h100);
    rd(8'h08, v); chk("R2 busy write ignored", v, 0);
  endtask

  task automatic t_count();
    logic [31:0] v;
    tick();
    rd(8'h04, v); chk("R4 disabled holds", v, 32'h100);
    rd(8'h00, v); chk("R5 no flag when disabled", v[6], 0);
    wr(8'h00, 32'h01);
    tick();
    rd(8'h04, v); chk("R4 increment", v, 32'h101);
    rd(8'h00, v); chk("R5 flag set", v[6], 1);
    wr(8'h00, 32'h41);
    rd(8'h00, v); chk("R7 write 1 keeps flag", v[6], 1);
    wr(8'h00, 32'h61);
    chk("R8 irq on flag+enable", irq, 1);
    wr(8'h00, 32'h21);
    rd(8'h00, v); chk("R7 write 0 clears flag", v[6], 0);
    chk("R8 irq drops", irq, 0);
    wr(8'h04, 32'hFFFF_FFFF);
    tick();
    rd(8'h04, v); chk("R4 wrap", v, 0);
    chk("R8 irq from second flag", irq, 1);
  endtask

  task automatic t_alarm();
    logic [31:0] v;
    wr(8'h08, 32'h2);
    wr(8'h00, 32'h0D);
    rd(8'h00, v); chk("R6 no alarm before match", v[4], 0);
    chk("R8 irq quiet", irq, 0);
    tick();
    tick();
    @(negedge clk);
    rd(8'h04, v); chk("R4 reached alarm", v, 2);
    rd(8'h00, v); chk("R6 alarm flag", v[4], 1);
    chk("R8 irq on alarm", irq, 1);
    tick();
    wr(8'h00, 32'h0D);
    rd(8'h00, v); chk("R7 alarm flag cleared", v[4], 0);
    chk("R8 irq after clear", irq, 0);
  endtask

  task automatic t_misc();
    logic [31:0] v;
    wr(8'h20, 32'h0);
    chk("R9 zero write no request", poweroff_req, 0);
    wr(8'h20, 32'h1);
    chk("R9 request raised", poweroff_req, 1);
    wr(8'h20, 32'h0);
    chk("R9 request held", poweroff_req, 1);
    wr(8'h34, 32'h1234_5678);
    rd(8'h34, v); chk("R10 scratchpad", v, 32'h1234_5678);
    wr(8'h0C, 32'hA5A5_0F0F);
    rd(8'h0C, v); chk("R10 regulator", v, 32'hA5A5_0F0F);
  endtask

  initial begin
    rst_n = 1'b0; tick_1hz = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_commit();
    t_count();
    t_alarm();
    t_misc();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule